// File: doc/BRIEF.md
# Three-Phase Apparent Energy Accumulator

This block integrates the filtered average apparent power of three phases into three energy counters. Each phase supplies an unsigned power word. The block trims that word by a signed per-phase gain and divides it by a shared divisor. On every sample tick it adds the result to a 40-bit unsigned accumulator. The block generates the sample tick itself, once every four clocks.

Software uses a small register port. It reads the top 16 bits of each accumulator and sets the gains, the divisor, an interrupt mask and a mode word. When the most significant bit of any accumulator changes, a sticky status flag is set, so the host can collect energy before a counter wraps. A mode bit makes each energy read clear the counter it reads. If that clear falls in the same cycle as a sample tick, the tick's energy is kept.

Top module: `tri_va_energy`

## Requirements
- R1: After reset, every accumulator, gain, divisor, mask, mode and status field is zero, `irq_o` is low and `reg_rdata_o` is zero.
- R2: With power P and 12-bit two's complement gain G, the per-tick increment is floor(P × (4096 + G) / 4096). Gain 0x800 halves the power and gain 0x7FF raises it by about 50%.
- R3: A divisor D of 0 or 1 leaves the increment undivided. Any other D replaces the increment with floor(increment / D), and the remainder is discarded.
- R4: One increment is added every fourth clock, so any run of 4·N consecutive clock edges adds exactly N increments to each accumulator.
- R5: A read of address 0, 1 or 2 returns bits [39:24] of that phase's accumulator on `reg_rdata_o` after the clock edge that samples `reg_rd_i`.
- R6: An accumulator counts modulo 2^40: on overflow it wraps past zero and keeps counting upward.
- R7: When bit 6 of the mode register (address 10) is set, reading a phase's energy clears that accumulator. When the bit is clear, reads leave the accumulator untouched.
- R8: When a clearing read and a sample tick fall on the same edge, the accumulator is loaded with that tick's increment alone.
- R9: Status bit 2 (address 11) is set on the edge where bit 39 of any accumulator changes value. It holds until the host writes 1 to bit 2 of address 11, and a change on that same edge wins over the clear.
- R10: `irq_o` is high exactly while status bit 2 and bit 2 of the mask register (address 9) are both set.
- R11: Gains of phases 0, 1 and 2 are at addresses 4, 5 and 6 and read back zero-extended. The divisor is at address 8. Mask and mode are full 16-bit read/write words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_i | input | 3·PWR_W | Average apparent power per phase, phase 0 in the low bits |
| reg_addr_i | input | 4 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Half-full interrupt, masked |

## Verification
Read data appears one edge after the read strobe. A status or interrupt change becomes visible on the same edge that moves bit 39 of an accumulator, and a written gain, divisor or mode takes effect on the following edge. The phase of the internal tick is unknown to the bench, so every energy check measures a window that is a whole multiple of four edges, counted from the clearing read. Such a window holds an exact number of ticks at any phase. Interrupt checks are placed one tick before and one tick after the computed crossing point, and all outputs are sampled on the falling edge.

// File: rtl/vae_pkg.sv
package vae_pkg;
  // register map of the block
  localparam int ADDR_W      = 4;
  localparam int A_GAIN_BASE = 4;
  localparam int A_DIV       = 8;
  localparam int A_MASK      = 9;
  localparam int A_MODE      = 10;
  localparam int A_STATUS    = 11;
  // bit positions the block decodes
  localparam int HALF_BIT    = 2;   // mask enable and status flag
  localparam int RDCLR_BIT   = 6;   // clear-on-read in mode word
endpackage

// File: rtl/vae_tick.sv
module vae_tick #(
  parameter int SMP_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe_o
);
  localparam int CNT_W = (SMP_DIV > 2) ? $clog2(SMP_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SMP_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign strobe_o = (cnt_q == LAST);

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o); // R4
endmodule

// File: rtl/vae_scale.sv
module vae_scale #(
  parameter int PWR_W  = 24,
  parameter int GAIN_W = 12,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PWR_W-1:0]  pwr_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [PWR_W:0]    inc_o
);
  localparam int INC_W  = PWR_W + 1;
  localparam int FACT_W = GAIN_W + 1;
  localparam int PROD_W = PWR_W + FACT_W;
  localparam logic [FACT_W-1:0] UNITY = FACT_W'(1) << GAIN_W;

  // power x (1 + g / 2^GAIN_W), truncated
  function automatic logic [INC_W-1:0] trim_power(
    input logic [PWR_W-1:0] p, input logic [GAIN_W-1:0] g);
    logic [FACT_W-1:0] f;
    logic [PROD_W-1:0] prod;
    f    = UNITY + {g[GAIN_W-1], g};
    prod = PROD_W'(p) * PROD_W'(f);
    return prod[PROD_W-1:GAIN_W];
  endfunction

  // divisor 0 and 1 bypass, otherwise truncating division
  function automatic logic [INC_W-1:0] scale_down(
    input logic [INC_W-1:0] x, input logic [DIV_W-1:0] d);
    if (d <= DIV_W'(1)) return x;
    return x / INC_W'(d);
  endfunction

  logic [INC_W-1:0] gained;

  assign gained = trim_power(pwr_i, gain_i);
  assign inc_o  = scale_down(gained, div_i);

  AST_GAIN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    gained >= INC_W'(pwr_i >> 1)); // R2
  AST_GAIN_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    gained <= INC_W'(pwr_i) + INC_W'(pwr_i >> 1)); // R2
  AST_DIV_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i > DIV_W'(1)) |-> (inc_o <= (gained >> 1))); // R3
endmodule

// File: rtl/vae_phase_acc.sv
module vae_phase_acc #(
  parameter int INC_W = 25,
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             msb_evt_o
);
  localparam int TOP = ACC_W - 1;

  logic [ACC_W-1:0] acc_q, acc_d, addend;

  assign addend = strobe_i ? ACC_W'(inc_i) : '0;

  always_comb begin
    if (clr_i) acc_d = addend;            // keep the coincident tick
    else       acc_d = acc_q + addend;    // wraps modulo 2^ACC_W
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o     = acc_q;
  assign msb_evt_o = rst_n && (acc_d[TOP] != acc_q[TOP]);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i && !clr_i) |=> $stable(acc_q)); // R4
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !strobe_i) |=> (acc_q == '0)); // R7
  AST_CLR_KEEPS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && strobe_i && (inc_i != '0)) |=> (acc_q != '0)); // R8
  AST_ONLY_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((acc_q >= $past(acc_q)) || ($past(acc_q[TOP]) && !acc_q[TOP]))); // R6
endmodule

// File: rtl/vae_regs.sv
module vae_regs
  import vae_pkg::*;
#(
  parameter int NPH    = 3,
  parameter int GAIN_W = 12,
  parameter int DIV_W  = 8,
  parameter int ACC_W  = 40,
  parameter int RD_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [RD_W-1:0]       wdata_i,
  output logic [RD_W-1:0]       rdata_o,
  input  logic [NPH*ACC_W-1:0]  acc_i,
  input  logic [NPH-1:0]        msb_evt_i,
  output logic [NPH*GAIN_W-1:0] gain_o,
  output logic [DIV_W-1:0]      div_o,
  output logic [NPH-1:0]        clr_o,
  output logic                  irq_o
);
  logic [NPH-1:0][GAIN_W-1:0] gain_q;
  logic [DIV_W-1:0]           div_q;
  logic [RD_W-1:0]            mask_q, mode_q, rd_mux, rdata_q;
  logic                       status_q, status_d, w1c;

  // configuration writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q <= '0;
      div_q  <= '0;
      mask_q <= '0;
      mode_q <= '0;
    end else if (wr_i) begin
      for (int p = 0; p < NPH; p++)
        if (addr_i == ADDR_W'(A_GAIN_BASE + p)) gain_q[p] <= wdata_i[GAIN_W-1:0];
      if (addr_i == ADDR_W'(A_DIV))  div_q  <= wdata_i[DIV_W-1:0];
      if (addr_i == ADDR_W'(A_MASK)) mask_q <= wdata_i;
      if (addr_i == ADDR_W'(A_MODE)) mode_q <= wdata_i;
    end
  end

  // sticky half-full flag, write one to clear, a new event wins
  assign w1c      = wr_i && (addr_i == ADDR_W'(A_STATUS)) && wdata_i[HALF_BIT];
  assign status_d = (status_q && !w1c) || (|msb_evt_i);

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= status_d;
  end

  assign irq_o = status_q && mask_q[HALF_BIT];

  // clearing reads
  always_comb begin
    for (int p = 0; p < NPH; p++)
      clr_o[p] = rd_i && (addr_i == ADDR_W'(p)) && mode_q[RDCLR_BIT];
  end

  // read multiplexer
  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPH; p++) begin
      if (addr_i == ADDR_W'(p))
        rd_mux = acc_i[p*ACC_W + ACC_W - 1 -: RD_W];
      if (addr_i == ADDR_W'(A_GAIN_BASE + p))
        rd_mux = RD_W'(gain_q[p]);
    end
    if (addr_i == ADDR_W'(A_DIV))    rd_mux = RD_W'(div_q);
    if (addr_i == ADDR_W'(A_MASK))   rd_mux = mask_q;
    if (addr_i == ADDR_W'(A_MODE))   rd_mux = mode_q;
    if (addr_i == ADDR_W'(A_STATUS)) rd_mux = RD_W'(status_q) << HALF_BIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign gain_o  = gain_q;
  assign div_o   = div_q;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !w1c) |=> status_q); // R9
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|msb_evt_i) |=> status_q); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[HALF_BIT] |-> !irq_o); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_q)); // R5
endmodule

// File: rtl/tri_va_energy.sv
module tri_va_energy
  import vae_pkg::*;
#(
  parameter int NPH     = 3,
  parameter int PWR_W   = 24,
  parameter int GAIN_W  = 12,
  parameter int DIV_W   = 8,
  parameter int ACC_W   = 40,
  parameter int RD_W    = 16,
  parameter int SMP_DIV = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPH*PWR_W-1:0] pwr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [RD_W-1:0]      reg_wdata_i,
  output logic [RD_W-1:0]      reg_rdata_o,
  output logic                 irq_o
);
  localparam int INC_W = PWR_W + 1;

  logic                  strobe;
  logic [NPH*GAIN_W-1:0] gain_all;
  logic [DIV_W-1:0]      div_val;
  logic [NPH-1:0]        clr, msb_evt;
  logic [NPH*ACC_W-1:0]  acc_all;

  vae_tick #(.SMP_DIV(SMP_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .strobe_o(strobe));

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic [INC_W-1:0] inc;

    vae_scale #(.PWR_W(PWR_W), .GAIN_W(GAIN_W), .DIV_W(DIV_W)) u_scale (
      .clk(clk), .rst_n(rst_n),
      .pwr_i(pwr_i[p*PWR_W +: PWR_W]),
      .gain_i(gain_all[p*GAIN_W +: GAIN_W]),
      .div_i(div_val),
      .inc_o(inc));

    vae_phase_acc #(.INC_W(INC_W), .ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n),
      .strobe_i(strobe), .clr_i(clr[p]), .inc_i(inc),
      .acc_o(acc_all[p*ACC_W +: ACC_W]),
      .msb_evt_o(msb_evt[p]));
  end

  vae_regs #(.NPH(NPH), .GAIN_W(GAIN_W), .DIV_W(DIV_W),
             .ACC_W(ACC_W), .RD_W(RD_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .addr_i(reg_addr_i), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .acc_i(acc_all), .msb_evt_i(msb_evt),
    .gain_o(gain_all), .div_o(div_val), .clr_o(clr), .irq_o(irq_o));
endmodule

// File: tb/tri_va_energy_tb_top.sv
`timescale 1ns/1ps
module tri_va_energy_tb_top;
  localparam int PW = 32;
  localparam longint TWO40 = 64'h100_0000_0000;
  localparam longint TWO39 = 64'h080_0000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3*PW-1:0] pwr = '0;
  logic [3:0]    reg_addr = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic          irq;

  int checks = 0, errors = 0;
  longint tick_n = 0, t_mark = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) tick_n <= tick_n + 1;

  tri_va_energy #(.PWR_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_i(pwr),
    .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq));

  typedef struct packed {
    logic [31:0] p0, p1, p2;
    logic [11:0] g0, g1, g2;
    logic [7:0]  dv;
    logic [15:0] n;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h1000_0000, 32'h2000_0000, 32'h0123_4567, 12'h000, 12'h000, 12'h000, 8'd0,   16'd20},
    '{32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 12'h800, 12'h7FF, 12'h001, 8'd1,   16'd30},
    '{32'hF000_0000, 32'h3333_3333, 32'hABCD_EF01, 12'hFFF, 12'h400, 12'hC00, 8'd2,   16'd25},
    '{32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h7654_3210, 12'h123, 12'hE00, 12'h000, 8'd255, 16'd100},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 12'h7FF, 12'h7FF, 12'h7FF, 8'd0,   16'd200},
    '{32'h9000_0001, 32'h0FFF_FFFF, 32'hC000_0000, 12'h801, 12'h100, 12'hF80, 8'd3,   16'd40}
  };

  // requirement model: per-tick increment
  function automatic longint exp_inc(longint p, logic [11:0] g, logic [7:0] d);
    longint gs, r;
    gs = g[11] ? longint'(g) - 4096 : longint'(g);
    r  = (p * (4096 + gs)) / 4096;
    if (d > 8'd1) r = r / longint'(d);
    return r;
  endfunction

  function automatic longint exp_top(longint n, longint inc);
    return ((n * inc) % TWO40) / 64'd16777216;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [15:0] v);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic idle_to(input longint e);
    while (tick_n - t_mark < e) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    longint inc, kc, kw;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 irq", irq, 0);
    idle(9);
    do_rd(4'd0, v);  chk("R1 energy0", v, 0);
    do_rd(4'd5, v);  chk("R1 gain1", v, 0);
    do_rd(4'd10, v); chk("R1 mode", v, 0);
    do_rd(4'd11, v); chk("R1 status", v, 0);

    // R11: configuration read-back
    do_wr(4'd4, 16'h0ABC); do_rd(4'd4, v); chk("R11 gain0", v, 16'h0ABC);
    do_wr(4'd8, 16'h00C7); do_rd(4'd8, v); chk("R11 divisor", v, 16'h00C7);
    do_wr(4'd9, 16'hFFFB); do_rd(4'd9, v); chk("R11 mask", v, 16'hFFFB);
    do_wr(4'd9, 16'h0000);

    // R2 R3 R4 R5 R6: table of vectors, windows of 4n edges after clearing reads
    for (int i = 0; i < 6; i++) begin
      do_wr(4'd4, {4'h0, VECS[i].g0});
      do_wr(4'd5, {4'h0, VECS[i].g1});
      do_wr(4'd6, {4'h0, VECS[i].g2});
      do_wr(4'd8, {8'h00, VECS[i].dv});
      do_wr(4'd10, 16'h0040);
      pwr = {VECS[i].p2, VECS[i].p1, VECS[i].p0};
      do_rd(4'd0, v); do_rd(4'd1, v); do_rd(4'd2, v);
      idle(4 * int'(VECS[i].n) - 3);
      do_rd(4'd0, v);
      chk("R2 R3 R5 phase0", v, exp_top(VECS[i].n, exp_inc(VECS[i].p0, VECS[i].g0, VECS[i].dv)));
      do_rd(4'd1, v);
      chk("R2 R4 R6 phase1", v, exp_top(VECS[i].n, exp_inc(VECS[i].p1, VECS[i].g1, VECS[i].dv)));
      do_rd(4'd2, v);
      chk("R3 R4 R6 phase2", v, exp_top(VECS[i].n, exp_inc(VECS[i].p2, VECS[i].g2, VECS[i].dv)));
    end

    // R8: clearing read at every phase of the tick
    do_wr(4'd4, 16'h0000); do_wr(4'd8, 16'h0000);
    pwr = {32'h0, 32'h0, 32'h8000_0000};
    inc = exp_inc(64'h8000_0000, 12'h000, 8'd0);
    for (int off = 0; off < 4; off++) begin
      idle(off);
      do_rd(4'd0, v);
      idle(4 * 5 - 1);
      do_rd(4'd0, v);
      chk("R8 clear with tick", v, exp_top(5, inc));
    end

    // R7: reads without the clear mode leave the accumulator alone
    pwr = {32'h0, 32'h0, 32'h4000_0000};
    inc = exp_inc(64'h4000_0000, 12'h000, 8'd0);
    do_rd(4'd0, v);
    do_wr(4'd10, 16'h0000);
    idle(4 * 10 - 2);
    do_rd(4'd0, v); chk("R7 no clear first", v, exp_top(10, inc));
    idle(4 * 6 - 1);
    do_rd(4'd0, v); chk("R7 no clear second", v, exp_top(16, inc));

    // R9 R10: half-full flag and interrupt
    do_wr(4'd4, 16'h07FF);
    do_wr(4'd10, 16'h0040);
    do_wr(4'd9, 16'h0004);
    pwr = {32'h0, 32'h0, 32'hFFFF_FFFF};
    inc = exp_inc(64'hFFFF_FFFF, 12'h7FF, 8'd0);
    kc = (TWO39 + inc - 1) / inc;
    kw = (TWO40 + inc - 1) / inc;
    do_rd(4'd0, v); t_mark = tick_n - 1;
    do_rd(4'd1, v); do_rd(4'd2, v);
    do_wr(4'd11, 16'h0004);
    idle_to(4 * (kc - 1));
    chk("R10 irq before half", irq, 0);
    idle_to(4 * kc);
    chk("R10 irq at half", irq, 1);
    do_rd(4'd11, v); chk("R9 status set", v, 16'h0004);
    do_wr(4'd9, 16'h0000);
    chk("R10 irq masked", irq, 0);
    do_rd(4'd11, v); chk("R9 status sticky", v, 16'h0004);
    do_wr(4'd9, 16'h0004);
    chk("R10 irq unmasked", irq, 1);
    do_wr(4'd11, 16'h0004);
    chk("R9 w1c irq", irq, 0);
    do_rd(4'd11, v); chk("R9 w1c status", v, 16'h0000);
    idle_to(4 * (kw - 1));
    chk("R9 no event before wrap", irq, 0);
    idle_to(4 * kw);
    chk("R9 wrap event", irq, 1);
    do_rd(4'd0, v); chk("R6 value after wrap", v, exp_top(kw, inc));

    finish_run();
  end
endmodule